// File: doc/BRIEF.md
# Block String Operation Engine

This engine is a multi-cycle unit that runs one block memory string operation at a time on three working registers. The first holds the destination or scan pointer. The second holds either the source pointer or a comparison value. The third holds the number of elements still to process. A one-cycle start pulse loads the three registers along with an opcode and an element size code. The engine then performs the operation through a single memory port that makes one access per request/acknowledge handshake.

On completion it pulses `done` for one cycle. At that point the final register values are on `r1_out`, `r2_out` and `r3_out`. The scan and compare operations also update a carry flag and a zero flag. Each of these operations stops under its own condition and sets the two flags by its own rule.

Seven operations are supported:
- forward and backward byte copy;
- byte copy that ends after a zero byte has been copied;
- fill with elements of 1, 2 or 4 bytes;
- element scan that stops on a match;
- element scan that stops on a mismatch;
- byte-string compare.

Memory faults and interruption partway through an operation are not part of this block.

Top module: `strop_engine`

## Requirements
- R1: After a synchronous active-low reset, `busy`, `done`, `mem_req`, `flag_c` and `flag_z` are 0, all three register outputs are 0, and no request is made while `busy` is low.
- R2: Opcode 0 (forward copy) repeats one step until the count reaches 0. Each step reads a byte at the source pointer, writes it at the destination pointer, adds 1 to both pointers and subtracts 1 from the count.
- R3: Opcode 1 (backward copy) is the same as opcode 0, except that both pointers are decremented by 1, wrapping modulo 2^AW.
- R4: Opcode 2 runs as forward copy but ends right after the step that copies a zero byte, or when the count reaches 0.
- R5: Opcode 3 (fill) writes the low bytes of the second register at the destination pointer, then advances that pointer by the element size and decrements the count until it reaches 0. Size code 0 selects 1 byte, code 1 selects 2 bytes, and codes 2 and 3 select 4 bytes. `mem_size` carries the code actually used (0, 1 or 2).
- R6: Opcode 4 (scan for match) reads one element per step at the scan pointer, zero-extended from the low lanes of `mem_rdata` with the upper lanes ignored. Each step advances the pointer and decrements the count, and the scan ends when the element equals the 32-bit comparison value. At the end, `flag_z` is 1 exactly when element minus value is zero, and `flag_c` is 1 when element ≤ value (unsigned).
- R7: Opcode 5 (scan while matching) steps like opcode 4 but ends on the first element that differs from the value. At the end, `flag_z` is 1 exactly when the remaining count is 0, and `flag_c` is 1 when element ≤ value.
- R8: Opcode 6 (compare) reads a byte at the first pointer, then a byte at the second pointer. It advances both pointers by 1 and decrements the count. It ends when the bytes differ or the first byte is 0. At the end, `flag_z` is 1 when the bytes are equal, and `flag_c` is 1 when first ≥ second.
- R9: A start with a zero count makes no memory access, pulses `done` one cycle after the start, and returns the loaded registers unchanged. The flags change only in the `done` cycle of an opcode 4, 5 or 6 run with a non-zero count.
- R10: A request holds its address, direction, size and write data stable until `mem_ack`. Exactly one access completes per acknowledged cycle, reads precede the write within a copy step, and `done` is high for a single cycle.
- R11: A start pulse while `busy` is high has no effect on the running operation, and a start carrying opcode 7 is ignored (the engine stays idle).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle launch pulse |
| start_op | input | 3 | Operation code (0..6 valid) |
| start_size | input | 2 | Element size code for fill and scans |
| r1_in | input | AW | Destination / scan pointer at launch |
| r2_in | input | AW | Source pointer or comparison value at launch |
| r3_in | input | CW | Element count at launch |
| busy | output | 1 | Operation in progress (including the done cycle) |
| done | output | 1 | One-cycle completion pulse |
| r1_out | output | AW | Current first register |
| r2_out | output | AW | Current second register |
| r3_out | output | CW | Current count |
| flag_c | output | 1 | Carry flag |
| flag_z | output | 1 | Zero flag |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 for write, 0 for read |
| mem_addr | output | AW | Byte address of the access |
| mem_size | output | 2 | Access width code: 0=1, 1=2, 2=4 bytes |
| mem_wdata | output | 32 | Write data, little-endian in the low lanes |
| mem_ack | input | 1 | Access completes in this cycle |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |

## Verification
The hardest conditions to reach from the ports are the early stops, because each depends on what memory holds rather than on the start inputs. Examples are a zero byte partway through a copy, a matching element deep inside a scan, and a NUL or a mismatch partway through a compare.

The bench reaches them by writing chosen bytes into its memory model before each launch. It fills the upper read-data lanes with random values so that a missing lane mask shows up, and it answers requests after random delays so that the hold-until-acknowledge path is exercised. It also pulses start in the middle of a long copy, and it reruns zero-count operations after flag-setting runs, so that unchanged flags can be seen at the ports.

// File: rtl/strop_pkg.sv
// Shared types and helpers for the string operation engine.
// Assumes elements are at most 32 bits wide and memory is byte addressed.
package strop_pkg;

    localparam int ELEM_W = 32;

    typedef enum logic [2:0] {
        OP_CPY_FWD = 3'd0,
        OP_CPY_BWD = 3'd1,
        OP_CPY_NUL = 3'd2,
        OP_FILL    = 3'd3,
        OP_SCAN_EQ = 3'd4,
        OP_SCAN_NE = 3'd5,
        OP_CMP     = 3'd6,
        OP_NONE    = 3'd7
    } strop_op_e;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_LOAD_A = 3'd1,
        ST_LOAD_B = 3'd2,
        ST_STORE  = 3'd3,
        ST_FINISH = 3'd4
    } strop_st_e;

    function automatic logic op_is_copy(strop_op_e op);
        return (op == OP_CPY_FWD) || (op == OP_CPY_BWD) || (op == OP_CPY_NUL);
    endfunction

    function automatic logic op_is_scan(strop_op_e op);
        return (op == OP_SCAN_EQ) || (op == OP_SCAN_NE);
    endfunction

    function automatic logic op_sets_flags(strop_op_e op);
        return op_is_scan(op) || (op == OP_CMP);
    endfunction

    // Effective size code: byte for copy/compare, clamped to 4 bytes otherwise.
    function automatic logic [1:0] eff_size(strop_op_e op, logic [1:0] sz);
        if (op_is_copy(op) || op == OP_CMP) return 2'd0;
        return (sz == 2'd3) ? 2'd2 : sz;
    endfunction

endpackage

// File: rtl/strop_eval.sv
// Stop-condition and flag evaluator for one element step.
// Purely combinational; inputs are already masked to the element width.
module strop_eval
    import strop_pkg::*;
#(
    parameter int CW = 32
) (
    input  strop_op_e          op,
    input  logic [ELEM_W-1:0]  elem_a,
    input  logic [ELEM_W-1:0]  elem_b,
    input  logic [ELEM_W-1:0]  cmp_val,
    input  logic [CW-1:0]      cnt_next,
    output logic               stop_hit,
    output logic               c_val,
    output logic               z_val
);

    // Decide early stop and the flag values per operation.
    always_comb begin
        stop_hit = 1'b0;
        c_val    = 1'b0;
        z_val    = 1'b0;
        unique case (op)
            OP_CPY_NUL: stop_hit = (elem_a[7:0] == 8'h00);
            OP_SCAN_EQ: begin
                stop_hit = (elem_a == cmp_val);
                z_val    = ((elem_a - cmp_val) == '0);
                c_val    = (elem_a <= cmp_val);
            end
            OP_SCAN_NE: begin
                stop_hit = (elem_a != cmp_val);
                z_val    = (cnt_next == '0);
                c_val    = (elem_a <= cmp_val);
            end
            OP_CMP: begin
                stop_hit = (elem_a[7:0] != elem_b[7:0]) || (elem_a[7:0] == 8'h00);
                z_val    = ((elem_a[7:0] - elem_b[7:0]) == 8'h00);
                c_val    = (elem_a[7:0] >= elem_b[7:0]);
            end
            default: stop_hit = 1'b0;
        endcase
    end

endmodule

// File: rtl/strop_memif.sv
// Memory port shaping: picks address, direction and width from the state,
// and masks read data to the element width lane by lane.
// Assumes AW >= 32 so the second register can carry a 32-bit fill value.
module strop_memif
    import strop_pkg::*;
#(
    parameter int AW = 32
) (
    input  strop_st_e          state,
    input  strop_op_e          op,
    input  logic [1:0]         esz,
    input  logic [AW-1:0]      r1,
    input  logic [AW-1:0]      r2,
    input  logic [ELEM_W-1:0]  dat_a,
    input  logic [ELEM_W-1:0]  mem_rdata,
    output logic               mem_req,
    output logic               mem_we,
    output logic [AW-1:0]      mem_addr,
    output logic [1:0]         mem_size,
    output logic [ELEM_W-1:0]  mem_wdata,
    output logic [ELEM_W-1:0]  rd_elem
);

    localparam int NLANE = ELEM_W / 8;

    // Drive request fields for the access the current state needs.
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = r1;
        mem_size  = esz;
        mem_wdata = (op == OP_FILL) ? r2[ELEM_W-1:0] : dat_a;
        unique case (state)
            ST_LOAD_A: begin
                mem_req  = 1'b1;
                mem_addr = op_is_copy(op) ? r2 : r1;
            end
            ST_LOAD_B: begin
                mem_req  = 1'b1;
                mem_addr = r2;
            end
            ST_STORE: begin
                mem_req  = 1'b1;
                mem_we   = 1'b1;
                mem_addr = r1;
            end
            default: mem_req = 1'b0;
        endcase
    end

    // Keep only the byte lanes covered by the element size.
    for (genvar k = 0; k < NLANE; k++) begin : g_lane
        assign rd_elem[8*k +: 8] = (k < (32'd1 << esz)) ? mem_rdata[8*k +: 8] : 8'h00;
    end

endmodule

// File: rtl/strop_core.sv
// Sequencer and working registers of the string engine.
// Assumes one memory access per acknowledge; no faults or aborts.
module strop_core
    import strop_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [2:0]         start_op,
    input  logic [1:0]         start_size,
    input  logic [AW-1:0]      r1_in,
    input  logic [AW-1:0]      r2_in,
    input  logic [CW-1:0]      r3_in,
    input  logic               mem_ack,
    input  logic [ELEM_W-1:0]  rd_elem,
    input  logic               stop_hit,
    input  logic               c_val,
    input  logic               z_val,
    output strop_st_e          state,
    output strop_op_e          op_q,
    output logic [1:0]         esz_q,
    output logic [AW-1:0]      r1_q,
    output logic [AW-1:0]      r2_q,
    output logic [CW-1:0]      r3_q,
    output logic [ELEM_W-1:0]  dat_a_q,
    output logic [ELEM_W-1:0]  eval_a,
    output logic [ELEM_W-1:0]  eval_b,
    output logic [CW-1:0]      cnt_next,
    output logic               flag_c,
    output logic               flag_z,
    output logic               busy,
    output logic               done
);

    strop_op_e     new_op;
    strop_st_e     nxt;
    logic          accept;
    logic          step_end;
    logic          finish;
    logic          adv_r2;
    logic [AW-1:0] step;
    logic [AW-1:0] r1_nxt;
    logic [AW-1:0] r2_nxt;

    // Launch decode and end-of-step detection.
    always_comb begin
        new_op   = strop_op_e'(start_op);
        accept   = (state == ST_IDLE) && start && (new_op != OP_NONE);
        step_end = mem_ack && (((state == ST_LOAD_A) && op_is_scan(op_q))
                               || (state == ST_LOAD_B) || (state == ST_STORE));
        cnt_next = r3_q - CW'(1);
        finish   = step_end && ((cnt_next == '0) || stop_hit);
        eval_a   = (state == ST_LOAD_A) ? rd_elem : dat_a_q;
        eval_b   = rd_elem;
        busy     = (state != ST_IDLE);
        done     = (state == ST_FINISH);
    end

    // Pointer arithmetic for the step in progress.
    always_comb begin
        step   = AW'(1) << esz_q;
        adv_r2 = op_is_copy(op_q) || (op_q == OP_CMP);
        r1_nxt = (op_q == OP_CPY_BWD) ? r1_q - AW'(1) : r1_q + step;
        r2_nxt = (op_q == OP_CPY_BWD) ? r2_q - AW'(1) : r2_q + step;
    end

    // Next-state selection.
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: if (accept) begin
                if (r3_in == '0)           nxt = ST_FINISH;
                else if (new_op == OP_FILL) nxt = ST_STORE;
                else                        nxt = ST_LOAD_A;
            end
            ST_LOAD_A: if (mem_ack) begin
                if (op_is_scan(op_q))   nxt = finish ? ST_FINISH : ST_LOAD_A;
                else if (op_q == OP_CMP) nxt = ST_LOAD_B;
                else                     nxt = ST_STORE;
            end
            ST_LOAD_B: if (mem_ack) nxt = finish ? ST_FINISH : ST_LOAD_A;
            ST_STORE: if (mem_ack) begin
                if (finish)              nxt = ST_FINISH;
                else if (op_q == OP_FILL) nxt = ST_STORE;
                else                     nxt = ST_LOAD_A;
            end
            ST_FINISH: nxt = ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // Working registers, first-load latch and flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q    <= OP_NONE;
            esz_q   <= 2'd0;
            r1_q    <= '0;
            r2_q    <= '0;
            r3_q    <= '0;
            dat_a_q <= '0;
            flag_c  <= 1'b0;
            flag_z  <= 1'b0;
        end else begin
            if (accept) begin
                op_q  <= new_op;
                esz_q <= eff_size(new_op, start_size);
                r1_q  <= r1_in;
                r2_q  <= r2_in;
                r3_q  <= r3_in;
            end
            if ((state == ST_LOAD_A) && mem_ack) dat_a_q <= rd_elem;
            if (step_end) begin
                r1_q <= r1_nxt;
                if (adv_r2) r2_q <= r2_nxt;
                r3_q <= cnt_next;
            end
            if (finish && op_sets_flags(op_q)) begin
                flag_c <= c_val;
                flag_z <= z_val;
            end
        end
    end

endmodule

// File: rtl/strop_engine.sv
// Top of the block string operation engine: sequencer, memory port
// shaping and step evaluator. Assumes AW >= 32.
module strop_engine
    import strop_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [2:0]     start_op,
    input  logic [1:0]     start_size,
    input  logic [AW-1:0]  r1_in,
    input  logic [AW-1:0]  r2_in,
    input  logic [CW-1:0]  r3_in,
    output logic           busy,
    output logic           done,
    output logic [AW-1:0]  r1_out,
    output logic [AW-1:0]  r2_out,
    output logic [CW-1:0]  r3_out,
    output logic           flag_c,
    output logic           flag_z,
    output logic           mem_req,
    output logic           mem_we,
    output logic [AW-1:0]  mem_addr,
    output logic [1:0]     mem_size,
    output logic [31:0]    mem_wdata,
    input  logic           mem_ack,
    input  logic [31:0]    mem_rdata
);

    strop_st_e          state;
    strop_op_e          op_q;
    logic [1:0]         esz_q;
    logic [ELEM_W-1:0]  dat_a_q;
    logic [ELEM_W-1:0]  eval_a;
    logic [ELEM_W-1:0]  eval_b;
    logic [ELEM_W-1:0]  rd_elem;
    logic [CW-1:0]      cnt_next;
    logic               stop_hit;
    logic               c_val;
    logic               z_val;

    strop_core #(.AW(AW), .CW(CW)) u_core (
        .clk(clk), .rst_n(rst_n), .start(start), .start_op(start_op),
        .start_size(start_size), .r1_in(r1_in), .r2_in(r2_in), .r3_in(r3_in),
        .mem_ack(mem_ack), .rd_elem(rd_elem), .stop_hit(stop_hit),
        .c_val(c_val), .z_val(z_val), .state(state), .op_q(op_q),
        .esz_q(esz_q), .r1_q(r1_out), .r2_q(r2_out), .r3_q(r3_out),
        .dat_a_q(dat_a_q), .eval_a(eval_a), .eval_b(eval_b),
        .cnt_next(cnt_next), .flag_c(flag_c), .flag_z(flag_z),
        .busy(busy), .done(done)
    );

    strop_memif #(.AW(AW)) u_memif (
        .state(state), .op(op_q), .esz(esz_q), .r1(r1_out), .r2(r2_out),
        .dat_a(dat_a_q), .mem_rdata(mem_rdata), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_size(mem_size),
        .mem_wdata(mem_wdata), .rd_elem(rd_elem)
    );

    strop_eval #(.CW(CW)) u_eval (
        .op(op_q), .elem_a(eval_a), .elem_b(eval_b),
        .cmp_val(r2_out[ELEM_W-1:0]), .cnt_next(cnt_next),
        .stop_hit(stop_hit), .c_val(c_val), .z_val(z_val)
    );

endmodule

// File: rtl/strop_engine_chk.sv
// Port-level protocol checks for the string engine, bound to its top.
module strop_engine_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          busy,
    input logic          done,
    input logic          mem_req,
    input logic          mem_ack,
    input logic          mem_we,
    input logic [AW-1:0] mem_addr,
    input logic [1:0]    mem_size,
    input logic [31:0]   mem_wdata,
    input logic          flag_c,
    input logic          flag_z
);

    // R10
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                                   && $stable(mem_size) && $stable(mem_wdata)));

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req);

    // R11
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);

    // R11
    launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

    // R9
    flag_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((flag_c != $past(flag_c)) || (flag_z != $past(flag_z))) |-> done);

endmodule

bind strop_engine strop_engine_chk #(.AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .mem_req(mem_req), .mem_ack(mem_ack), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_size(mem_size), .mem_wdata(mem_wdata),
    .flag_c(flag_c), .flag_z(flag_z)
);

// File: tb/strop_engine_bench.sv
// Bench: behavioural memory and reference model; every access and every
// completion is compared against queues computed before launch.
module strop_engine_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  start_op = 3'd0;
    logic [1:0]  start_size = 2'd0;
    logic [31:0] r1_in = '0, r2_in = '0, r3_in = '0;
    logic        busy, done, flag_c, flag_z;
    logic [31:0] r1_out, r2_out, r3_out;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr;
    logic [1:0]  mem_size;
    logic [31:0] mem_wdata;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;

    strop_engine u_strop_engine (
        .clk(clk), .rst_n(rst_n), .start(start), .start_op(start_op),
        .start_size(start_size), .r1_in(r1_in), .r2_in(r2_in), .r3_in(r3_in),
        .busy(busy), .done(done), .r1_out(r1_out), .r2_out(r2_out),
        .r3_out(r3_out), .flag_c(flag_c), .flag_z(flag_z),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_size(mem_size), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
        .mem_rdata(mem_rdata)
    );

    always #2.5 clk = ~clk;

    logic [7:0]  mem [256];
    logic [7:0]  ref_mem [256];
    logic [31:0] q_addr[$];
    logic        q_we[$];
    logic [1:0]  q_size[$];
    logic [31:0] q_data[$];
    logic [31:0] exp_r1, exp_r2, exp_r3;
    logic        exp_c = 1'b0, exp_z = 1'b0;
    logic        expect_done = 1'b0;
    string       tag = "R1";
    int          n_checks = 0, n_fail = 0, done_cnt = 0;

    task automatic chk(bit ok, string req, longint act, longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] lane_mask(logic [1:0] es);
        return (es == 2'd0) ? 32'h000000FF : (es == 2'd1) ? 32'h0000FFFF : 32'hFFFFFFFF;
    endfunction

    function automatic logic [31:0] ref_load(logic [31:0] a, int nb);
        logic [31:0] v = '0;
        for (int k = 0; k < nb; k++) v[8*k +: 8] = ref_mem[8'(a + 32'(k))];
        return v;
    endfunction

    task automatic push_acc(logic [31:0] a, logic we, logic [1:0] es, logic [31:0] d);
        q_addr.push_back(a); q_we.push_back(we); q_size.push_back(es); q_data.push_back(d);
    endtask

    task automatic poke(int a, logic [7:0] v);
        mem[a] = v; ref_mem[a] = v;
    endtask

    // Reference model: expected access sequence, registers and flags.
    task automatic model_run(int op, int sz, logic [31:0] a1, logic [31:0] a2, logic [31:0] n3);
        logic [31:0] r1, r2, r3, e, b;
        logic [1:0]  es;
        int          nb;
        r1 = a1; r2 = a2; r3 = n3; e = '0; b = '0;
        es = (op == 3 || op == 4 || op == 5) ? ((sz == 3) ? 2'd2 : 2'(sz)) : 2'd0;
        nb = 1 << es;
        case (op)
            0, 1, 2: while (r3 != 0) begin
                b = {24'd0, ref_mem[r2[7:0]]};
                push_acc(r2, 1'b0, 2'd0, 32'd0);
                push_acc(r1, 1'b1, 2'd0, b);
                ref_mem[r1[7:0]] = b[7:0];
                if (op == 1) begin r1 = r1 - 1; r2 = r2 - 1; end
                else begin r1 = r1 + 1; r2 = r2 + 1; end
                r3 = r3 - 1;
                if (op == 2 && b == 0) break;
            end
            3: while (r3 != 0) begin
                push_acc(r1, 1'b1, es, r2);
                for (int k = 0; k < nb; k++) ref_mem[8'(r1 + 32'(k))] = r2[8*k +: 8];
                r1 = r1 + 32'(nb); r3 = r3 - 1;
            end
            4, 5: if (r3 != 0) begin
                while (r3 != 0) begin
                    e = ref_load(r1, nb);
                    push_acc(r1, 1'b0, es, 32'd0);
                    r1 = r1 + 32'(nb); r3 = r3 - 1;
                    if ((op == 4) ? (e == r2) : (e != r2)) break;
                end
                exp_c = (e <= r2);
                exp_z = (op == 4) ? (e == r2) : (r3 == 0);
            end
            6: if (r3 != 0) begin
                while (r3 != 0) begin
                    e = {24'd0, ref_mem[r1[7:0]]};
                    b = {24'd0, ref_mem[r2[7:0]]};
                    push_acc(r1, 1'b0, 2'd0, 32'd0);
                    push_acc(r2, 1'b0, 2'd0, 32'd0);
                    r1 = r1 + 1; r2 = r2 + 1; r3 = r3 - 1;
                    if (e != b || e == 0) break;
                end
                exp_z = (e == b);
                exp_c = (e >= b);
            end
            default: ;
        endcase
        exp_r1 = r1; exp_r2 = r2; exp_r3 = r3;
    endtask

    // Memory responder and completion monitor, acting on falling edges.
    initial begin
        logic        prev_done;
        logic [31:0] m, v;
        logic        ok;
        prev_done = 1'b0;
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (mem_req && !busy) chk(1'b0, "R1 request while idle", 1, 0);
                if (prev_done && done) chk(1'b0, "R10 done longer than one cycle", 1, 0);
                if (done) begin
                    done_cnt++;
                    chk(expect_done, {tag, " unexpected done"}, 32'(expect_done), 1);
                    chk(q_addr.size() == 0, {tag, " accesses missing at done"}, q_addr.size(), 0);
                    chk(r1_out == exp_r1, {tag, " first register"}, r1_out, exp_r1);
                    chk(r2_out == exp_r2, {tag, " second register"}, r2_out, exp_r2);
                    chk(r3_out == exp_r3, {tag, " count"}, r3_out, exp_r3);
                    chk(flag_c == exp_c, {tag, " carry flag"}, 32'(flag_c), 32'(exp_c));
                    chk(flag_z == exp_z, {tag, " zero flag"}, 32'(flag_z), 32'(exp_z));
                end
                prev_done = done;
                if (mem_ack) begin
                    mem_ack = 1'b0;
                end else if (mem_req && ($urandom % 3 != 0)) begin
                    m = lane_mask(mem_size);
                    if (q_addr.size() == 0) begin
                        chk(1'b0, {tag, "/R10 unexpected access"}, mem_addr, 0);
                    end else begin
                        ok = (mem_addr == q_addr[0]) && (mem_we == q_we[0]) && (mem_size == q_size[0])
                             && (!mem_we || ((mem_wdata & m) == (q_data[0] & m)));
                        chk(ok, {tag, "/R10 access"}, {mem_we, mem_size, mem_addr},
                            {q_we[0], q_size[0], q_addr[0]});
                        void'(q_addr.pop_front()); void'(q_we.pop_front());
                        void'(q_size.pop_front()); void'(q_data.pop_front());
                    end
                    if (mem_we) begin
                        for (int k = 0; k < (1 << mem_size); k++)
                            mem[8'(mem_addr + 32'(k))] = mem_wdata[8*k +: 8];
                    end else begin
                        v = '0;
                        for (int k = 0; k < (1 << mem_size); k++)
                            v[8*k +: 8] = mem[8'(mem_addr + 32'(k))];
                        mem_rdata = v | ($urandom & ~m);
                    end
                    mem_ack = 1'b1;
                end
            end
        end
    end

    task automatic run_op(string t, int op, int sz, logic [31:0] a1, logic [31:0] a2,
                          logic [31:0] n3, bit interfere);
        int base, w, bad;
        tag = t;
        model_run(op, sz, a1, a2, n3);
        base = done_cnt;
        expect_done = 1'b1;
        @(negedge clk);
        start = 1'b1; start_op = 3'(op); start_size = 2'(sz);
        r1_in = a1; r2_in = a2; r3_in = n3;
        @(negedge clk);
        start = 1'b0;
        if (interfere) begin
            repeat (3) @(negedge clk);
            start = 1'b1; start_op = 3'd3; start_size = 2'd2;
            r1_in = 32'h10; r2_in = 32'hDEADBEEF; r3_in = 32'd4;
            @(negedge clk);
            start = 1'b0;
        end
        w = 0;
        while (done_cnt == base && w < 5000) begin @(negedge clk); w++; end
        if (done_cnt == base) chk(1'b0, {t, " no completion"}, 0, 1);
        expect_done = 1'b0;
        @(negedge clk);
        chk(!busy && !done, {t, " idle after done"}, {busy, done}, 0);
        bad = 0;
        for (int i = 0; i < 256; i++) if (mem[i] !== ref_mem[i]) bad++;
        chk(bad == 0, {t, " memory contents"}, bad, 0);
    endtask

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "watchdog expired", 0, 1);
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) begin
            mem[i] = 8'(i * 37 + 11);
            ref_mem[i] = mem[i];
        end
        exp_r1 = '0; exp_r2 = '0; exp_r3 = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(!busy && !done && !mem_req, "R1 control outputs", {busy, done, mem_req}, 0);
        chk(!flag_c && !flag_z, "R1 flags", {flag_c, flag_z}, 0);
        chk(r1_out == 0 && r2_out == 0 && r3_out == 0, "R1 registers", r1_out | r2_out | r3_out, 0);

        run_op("R2 forward copy", 0, 0, 32'h80, 32'h10, 32'd8, 1'b0);
        run_op("R3 backward copy", 1, 0, 32'hC7, 32'h27, 32'd6, 1'b0);
        run_op("R3 backward copy wrap", 1, 0, 32'hE0, 32'h02, 32'd5, 1'b0);
        poke(8'h44, 8'h00);
        run_op("R4 copy to zero", 2, 0, 32'hA0, 32'h40, 32'd10, 1'b0);
        poke(8'h52, 8'h01); poke(8'h53, 8'h02); poke(8'h54, 8'h03);
        run_op("R4 copy count ends", 2, 0, 32'hB0, 32'h52, 32'd3, 1'b0);

        run_op("R5 fill byte", 3, 0, 32'h60, 32'hA1B2C3D4, 32'd3, 1'b0);
        run_op("R5 fill half", 3, 1, 32'h64, 32'hA1B2C3D4, 32'd3, 1'b0);
        run_op("R5 fill word", 3, 2, 32'h6C, 32'h11223344, 32'd2, 1'b0);
        run_op("R5 fill code3", 3, 3, 32'h74, 32'h55667788, 32'd2, 1'b0);

        for (int i = 0; i < 16; i++) poke(8'h30 + i, 8'h10 + 8'(i));
        poke(8'h35, 8'h5A);
        run_op("R6 scan match byte", 4, 0, 32'h30, 32'h5A, 32'd16, 1'b0);
        run_op("R6 scan no match", 4, 0, 32'h30, 32'h1FF, 32'd4, 1'b0);
        poke(8'h3C, 8'h34); poke(8'h3D, 8'h12);
        run_op("R6 scan match half", 4, 1, 32'h38, 32'h1234, 32'd4, 1'b0);
        run_op("R6 scan word above", 4, 2, 32'h30, 32'h0, 32'd2, 1'b0);

        for (int i = 0; i < 4; i++) poke(8'h70 + i, 8'h33);
        poke(8'h74, 8'h34);
        run_op("R7 scan while stop", 5, 0, 32'h70, 32'h33, 32'd10, 1'b0);
        run_op("R7 scan while exhaust", 5, 0, 32'h70, 32'h33, 32'd3, 1'b0);
        run_op("R7 scan while below", 5, 0, 32'h70, 32'h40, 32'd3, 1'b0);

        poke(8'h90, 8'h61); poke(8'h91, 8'h62); poke(8'h92, 8'h00);
        poke(8'hB0, 8'h61); poke(8'hB1, 8'h62); poke(8'hB2, 8'h00);
        run_op("R8 compare equal", 6, 0, 32'h90, 32'hB0, 32'd8, 1'b0);
        poke(8'hB1, 8'h63);
        run_op("R8 compare less", 6, 0, 32'h90, 32'hB0, 32'd8, 1'b0);
        run_op("R8 compare greater", 6, 0, 32'hB0, 32'h90, 32'd8, 1'b0);

        run_op("R9 zero count compare", 6, 0, 32'h90, 32'hB0, 32'd0, 1'b0);
        run_op("R9 zero count scan", 4, 0, 32'h30, 32'h5A, 32'd0, 1'b0);
        run_op("R9 zero count copy", 0, 0, 32'h80, 32'h10, 32'd0, 1'b0);
        run_op("R9 zero count fill", 3, 2, 32'h80, 32'h10, 32'd0, 1'b0);

        run_op("R11 start while busy", 0, 0, 32'hC0, 32'h00, 32'd20, 1'b1);
        // R11: opcode 7 must leave the engine idle
        @(negedge clk);
        start = 1'b1; start_op = 3'd7; r1_in = 32'h10; r3_in = 32'd4;
        @(negedge clk);
        start = 1'b0;
        repeat (3) @(negedge clk);
        chk(!busy && !mem_req && !done, "R11 opcode 7 ignored", {busy, mem_req, done}, 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule